// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block watches a free-running 64-bit system counter against a 64-bit absolute deadline. Software sets a 32-bit interval and turns the watchdog on. Every refresh moves the deadline to the current counter value plus the interval. If the counter reaches the deadline, a first-stage warning level rises and the deadline moves forward by one more interval. If the counter reaches the new deadline before any refresh, the reset-request level rises. The time from the last refresh to the reset request is therefore twice the interval.

Registers are reached through two address windows, each with its own select. The kick window holds a single write-only register: a write of any value is a refresh. The control window holds the control/status word, the interval and the two halves of the deadline. Both windows also show two identification words. The bus is a plain single-cycle read/write bus. A write takes effect at the clock edge where it is presented, and read data is combinational from the select and the address. The sticky reset-cause bit sits in a flop that only power-on reset clears. Software can therefore still read it after the system reset that the block itself requested.

Top module: `twostage_wdt`

## Requirements
- R1: After power-on reset the control/status word (control offset 0x000), the interval (0x008) and both deadline halves read 0, and `warn_o` and `reset_req_o` are low.
- R2: A write of any data to offset 0x000 of the kick window clears both stage flags and loads deadline = counter + interval, visible at the next read.
- R3: A write to control offset 0x000 sets the enable from data bit 0 and is also a refresh. Writing 0 stops the watchdog and drops both outputs.
- R4: A write to control offset 0x008 stores the 32-bit interval and is a refresh, so that the deadline becomes counter + the new interval.
- R5: While enabled, with the warning flag clear and counter >= deadline at a clock edge, the warning flag and `warn_o` rise at that edge and the deadline becomes counter + interval.
- R6: While enabled, with the warning flag set and counter >= deadline at an edge, the reset-cause flag sets at that edge. `reset_req_o` is high while that flag and the enable are both set.
- R7: While the enable is 0, no deadline is evaluated and neither flag sets, however far the counter runs.
- R8: A system reset (`rst_n` low) clears the enable, the warning flag, the interval and the deadline, but keeps the reset-cause flag, so `reset_req_o` falls. Only `por_n` or a refresh clears that flag.
- R9: The control/status word reads enable at bit 0, warning flag at bit 1 and reset-cause flag at bit 2, with the other bits 0. The deadline is written and read as a low half at 0x010 and a high half at 0x014. These writes are not refreshes.
- R10: In both windows offset 0xFCC reads the parameter `IFACE_ID` (default 0x0005A43B) and offset 0xFD0 reads `DEV_ID` (default 0x00001D01). Writes to them have no effect.
- R11: A refresh in the same cycle as an expiry wins: the warning flag stays clear and the deadline is reloaded from the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | System reset, active low, asynchronous; keeps the reset-cause flag |
| sys_cnt | input | 64 | Free-running system counter value |
| kick_sel | input | 1 | Selects the kick window |
| ctl_sel | input | 1 | Selects the control window |
| wr_en | input | 1 | Write strobe, 1 = write, 0 = read |
| addr | input | 12 | Byte offset inside the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the select and the address |
| warn_o | output | 1 | First-stage warning level (interrupt) |
| reset_req_o | output | 1 | Second-stage reset request level |

## Verification
A register write or an expiry is captured at one rising edge, and its effect is due directly after that edge. Read data is combinational, so a read is due in the same half cycle as its address. The bench presents each write or each new counter value at a falling edge and lets one rising edge pass. It then checks the outputs and reads registers at the next falling edge, one time unit after driving the address. A counter value one tick below the deadline is checked before the value that reaches it, so an expiry that comes one cycle early or one cycle late shows up at the ports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] OFS_KICK   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_IVAL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DL_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_DL_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_IFID   = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_DEVID  = 12'hFD0;

  // control/status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_WARN = 1;
  localparam int BIT_RST  = 2;

  typedef struct packed {
    logic refresh;
    logic ctl_wr;
    logic en_val;
    logic ival_wr;
    logic dl_lo_wr;
    logic dl_hi_wr;
  } wr_evt_t;
endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
  import wdt_pkg::*;
(
  input  logic              kick_sel,
  input  logic              ctl_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_bit,
  output wr_evt_t           evt
);
  logic kick_wr;

  always_comb begin
    kick_wr       = kick_sel && wr_en && (addr == OFS_KICK);
    evt.ctl_wr    = ctl_sel && wr_en && (addr == OFS_CTRL);
    evt.ival_wr   = ctl_sel && wr_en && (addr == OFS_IVAL);
    evt.dl_lo_wr  = ctl_sel && wr_en && (addr == OFS_DL_LO);
    evt.dl_hi_wr  = ctl_sel && wr_en && (addr == OFS_DL_HI);
    evt.en_val    = en_bit;
    evt.refresh   = kick_wr || evt.ctl_wr || evt.ival_wr;
  end
endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_all_n,
  input  wr_evt_t           evt,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  sys_cnt,
  output logic              en_q,
  output logic              ws0_q,
  output logic              ws1_q,
  output logic [DATA_W-1:0] ival_q,
  output logic [CNT_W-1:0]  dl_q
);
  logic              expired;
  logic [DATA_W-1:0] ival_src;
  logic [CNT_W-1:0]  next_dl;

  always_comb begin
    expired  = en_q && (sys_cnt >= dl_q);
    ival_src = evt.ival_wr ? wdata : ival_q;
    next_dl  = sys_cnt + {{(CNT_W-DATA_W){1'b0}}, ival_src};
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      en_q   <= 1'b0;
      ws0_q  <= 1'b0;
      ival_q <= '0;
      dl_q   <= '0;
    end else begin
      if (evt.ctl_wr)  en_q   <= evt.en_val;
      if (evt.ival_wr) ival_q <= wdata;
      if (evt.refresh) begin
        ws0_q <= 1'b0;
        dl_q  <= next_dl;
      end else begin
        if (evt.dl_lo_wr) dl_q[DATA_W-1:0]     <= wdata;
        if (evt.dl_hi_wr) dl_q[CNT_W-1:DATA_W] <= wdata;
        if (expired && !ws0_q) begin
          ws0_q <= 1'b1;
          dl_q  <= next_dl;
        end
      end
    end
  end

  // reset-cause flag survives the system reset it requests
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 ws1_q <= 1'b0;
    else if (evt.refresh)       ws1_q <= 1'b0;
    else if (expired && ws0_q)  ws1_q <= 1'b1;
  end
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] IFACE_ID = 32'h0005_A43B,
  parameter logic [DATA_W-1:0] DEV_ID   = 32'h0000_1D01
) (
  input  logic              kick_sel,
  input  logic              ctl_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_q,
  input  logic              ws0_q,
  input  logic              ws1_q,
  input  logic [DATA_W-1:0] ival_q,
  input  logic [CNT_W-1:0]  dl_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (ctl_sel || kick_sel) begin
      if (addr == OFS_IFID)       rdata = IFACE_ID;
      else if (addr == OFS_DEVID) rdata = DEV_ID;
    end
    if (ctl_sel) begin
      case (addr)
        OFS_CTRL: begin
          rdata[BIT_EN]   = en_q;
          rdata[BIT_WARN] = ws0_q;
          rdata[BIT_RST]  = ws1_q;
        end
        OFS_IVAL:  rdata = ival_q;
        OFS_DL_LO: rdata = dl_q[DATA_W-1:0];
        OFS_DL_HI: rdata = dl_q[CNT_W-1:DATA_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] IFACE_ID = 32'h0005_A43B,
  parameter logic [DATA_W-1:0] DEV_ID   = 32'h0000_1D01
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              kick_sel,
  input  logic              ctl_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              warn_o,
  output logic              reset_req_o
);
  wr_evt_t           evt;
  logic              rst_all_n;
  logic              en_q, ws0_q, ws1_q;
  logic [DATA_W-1:0] ival_q;
  logic [CNT_W-1:0]  dl_q;

  assign rst_all_n = rst_n & por_n;

  wdt_bus_decode u_dec (
    .kick_sel (kick_sel),
    .ctl_sel  (ctl_sel),
    .wr_en    (wr_en),
    .addr     (addr),
    .en_bit   (wdata[BIT_EN]),
    .evt      (evt)
  );

  wdt_stage_ctrl u_stage (
    .clk       (clk),
    .por_n     (por_n),
    .rst_all_n (rst_all_n),
    .evt       (evt),
    .wdata     (wdata),
    .sys_cnt   (sys_cnt),
    .en_q      (en_q),
    .ws0_q     (ws0_q),
    .ws1_q     (ws1_q),
    .ival_q    (ival_q),
    .dl_q      (dl_q)
  );

  wdt_read_mux #(.IFACE_ID(IFACE_ID), .DEV_ID(DEV_ID)) u_rd (
    .kick_sel (kick_sel),
    .ctl_sel  (ctl_sel),
    .addr     (addr),
    .en_q     (en_q),
    .ws0_q    (ws0_q),
    .ws1_q    (ws1_q),
    .ival_q   (ival_q),
    .dl_q     (dl_q),
    .rdata    (rdata)
  );

  assign warn_o      = ws0_q;
  assign reset_req_o = ws1_q & en_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              rst_all_n,
  input logic [CNT_W-1:0]  sys_cnt,
  input logic              kick_sel,
  input logic              ctl_sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              warn_o,
  input logic              reset_req_o,
  input logic              en_q,
  input logic              ws0_q,
  input logic              ws1_q,
  input logic [DATA_W-1:0] ival_q,
  input logic [CNT_W-1:0]  dl_q
);
  logic kick_w, refr_w;
  assign kick_w = kick_sel && wr_en && (addr == OFS_KICK);
  assign refr_w = kick_w || (ctl_sel && wr_en && (addr == OFS_CTRL || addr == OFS_IVAL));

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_all_n)
    kick_w |=> (!warn_o && !reset_req_o)); // R2

  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_all_n)
    (ctl_sel && wr_en && addr == OFS_CTRL && !wdata[BIT_EN]) |=> (!warn_o && !reset_req_o)); // R3

  AST_STAGE1_RELOAD: assert property (@(posedge clk) disable iff (!rst_all_n)
    (en_q && !ws0_q && sys_cnt >= dl_q && !wr_en)
      |=> (ws0_q && dl_q == $past(sys_cnt) + {{(CNT_W-DATA_W){1'b0}}, $past(ival_q)})); // R5

  AST_WARN_BEFORE_RESET: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(ws1_q) |-> ws0_q); // R6

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_all_n)
    !en_q |=> (!$rose(ws0_q) && !$rose(ws1_q))); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (ws1_q && !refr_w) |=> ws1_q); // R8
endmodule

bind twostage_wdt wdt_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rst_all_n   (rst_all_n),
  .sys_cnt     (sys_cnt),
  .kick_sel    (kick_sel),
  .ctl_sel     (ctl_sel),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .warn_o      (warn_o),
  .reset_req_o (reset_req_o),
  .en_q        (en_q),
  .ws0_q       (ws0_q),
  .ws1_q       (ws1_q),
  .ival_q      (ival_q),
  .dl_q        (dl_q)
);

// File: tb/twostage_wdt_tb.sv
`timescale 1ns/1ps
module twostage_wdt_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        kick_sel = 0, ctl_sel = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        warn_o, reset_req_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twostage_wdt u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .kick_sel(kick_sel), .ctl_sel(ctl_sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .warn_o(warn_o), .reset_req_o(reset_req_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write: presented at falling edge, captured at next rising edge
  task automatic wr(input bit kick, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    kick_sel = kick; ctl_sel = !kick; wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    kick_sel = 0; ctl_sel = 0; wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input string req, input bit kick, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    kick_sel = kick; ctl_sel = !kick; wr_en = 0; addr = a;
    #1;
    chk(req, rdata, exp);
    kick_sel = 0; ctl_sel = 0;
  endtask

  task automatic rd_dl(input string req, input logic [63:0] exp);
    rd(req, 0, 12'h010, exp[31:0]);
    rd(req, 0, 12'h014, exp[63:32]);
  endtask

  // new counter value at falling edge, one rising edge, check at falling edge
  task automatic tick(input logic [63:0] c);
    @(negedge clk);
    sys_cnt = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd("R1 ctrl", 0, 12'h000, 0);
    rd("R1 ival", 0, 12'h008, 0);
    rd_dl("R1 deadline", 64'h0);
    chk("R1 warn_o", warn_o, 0);
    chk("R1 reset_req_o", reset_req_o, 0);
  endtask

  task automatic t_ids;
    rd("R10 ctl ifid", 0, 12'hFCC, 32'h0005_A43B);
    rd("R10 ctl devid", 0, 12'hFD0, 32'h0000_1D01);
    rd("R10 kick ifid", 1, 12'hFCC, 32'h0005_A43B);
    rd("R10 kick devid", 1, 12'hFD0, 32'h0000_1D01);
    wr(0, 12'hFCC, 32'hFFFF_FFFF);
    wr(1, 12'hFD0, 32'h1234_5678);
    rd("R10 ifid after write", 0, 12'hFCC, 32'h0005_A43B);
    rd("R10 devid after write", 1, 12'hFD0, 32'h0000_1D01);
  endtask

  task automatic t_ival_kick;
    sys_cnt = 100;
    wr(0, 12'h008, 50);
    rd("R4 ival", 0, 12'h008, 50);
    rd_dl("R4 deadline after ival write", 64'd150);
    sys_cnt = 200;
    wr(1, 12'h000, 32'hDEAD_BEEF);
    rd_dl("R2 deadline after kick", 64'd250);
  endtask

  task automatic t_stages;
    sys_cnt = 1000;
    wr(0, 12'h000, 1);
    rd("R3 ctrl enabled", 0, 12'h000, 1);
    rd_dl("R3 deadline after ctrl write", 64'd1050);
    tick(1049);
    chk("R5 warn one tick early", warn_o, 0);
    tick(1050);
    chk("R5 warn_o at deadline", warn_o, 1);
    rd("R9 ctrl warn bit", 0, 12'h000, 3);
    rd_dl("R5 stage-two deadline", 64'd1100);
    tick(1099);
    chk("R6 reset_req one tick early", reset_req_o, 0);
    tick(1100);
    chk("R6 reset_req_o", reset_req_o, 1);
    rd("R6 ctrl both flags", 0, 12'h000, 7);
    wr(1, 12'h000, 0);
    chk("R2 warn cleared by kick", warn_o, 0);
    chk("R2 reset_req cleared by kick", reset_req_o, 0);
    rd("R2 ctrl after kick", 0, 12'h000, 1);
  endtask

  task automatic t_priority;
    sys_cnt = 5000;
    wr(1, 12'h000, 0);
    @(negedge clk);
    sys_cnt = 6000; kick_sel = 1; wr_en = 1; addr = 12'h000; wdata = 32'h5;
    @(posedge clk);
    @(negedge clk);
    kick_sel = 0; wr_en = 0; wdata = '0;
    chk("R11 warn stays low", warn_o, 0);
    rd_dl("R11 deadline from counter", 64'd6050);
  endtask

  task automatic t_disabled;
    wr(0, 12'h000, 0);
    rd("R3 ctrl stopped", 0, 12'h000, 0);
    tick(64'd9_000_000);
    tick(64'hFFFF_FFFF_FFFF_0000);
    chk("R7 warn_o while off", warn_o, 0);
    rd("R7 ctrl while off", 0, 12'h000, 0);
    wr(0, 12'h010, 32'h89AB_CDEF);
    wr(0, 12'h014, 32'h0123_4567);
    rd_dl("R9 deadline halves", 64'h0123_4567_89AB_CDEF);
    tick(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7 warn_o past deadline while off", warn_o, 0);
  endtask

  task automatic t_sysreset;
    sys_cnt = 7000;
    wr(0, 12'h000, 1);
    tick(7050);
    tick(7100);
    chk("R6 reset_req before sys reset", reset_req_o, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd("R8 ctrl keeps cause bit", 0, 12'h000, 4);
    rd("R8 ival cleared", 0, 12'h008, 0);
    chk("R8 reset_req low", reset_req_o, 0);
    chk("R8 warn low", warn_o, 0);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rd("R8 ctrl after power-on reset", 0, 12'h000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    t_reset();
    t_ids();
    t_ival_kick();
    t_stages();
    t_priority();
    t_disabled();
    t_sysreset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule